// File: doc/BRIEF.md
# Paged Descriptor Ring Address Generator

This block turns ring indices into bus addresses for three circular descriptor rings whose storage is scattered over separately placed memory pages. The device consumes the request ring and fills the completion ring and the message ring. For each ring the block holds a small table of page frame numbers and a free-running 32-bit device pointer. The pointer is masked to the ring length when it is used, and the masked index is split into a page select and a slot within that page. The page base plus the slot offset is the descriptor's bus address. The surrounding engine moves the descriptor bytes itself. It only asks this block where to read or write them.

Software loads page frame numbers one entry at a time, then commits a ring geometry. One commit covers the request and completion rings together. A separate commit covers the message ring. The block decides whether the request ring is empty from the host's producer index, and whether the message ring has room from the host's consumer index. It publishes the device-side indices that the host reads back.

Top module: `ring_addr_gen`

## Requirements
- R1: After reset every published index, every recorded length exponent and every result strobe is zero, and all three rings are in the not-set-up state.
- R2: A data setup records, for the request ring and for the completion ring, a length exponent equal to the bit width of (page count × entries per page − 1). Entries per page is 2^(PAGE_SHIFT − descriptor log2). The ring index mask is 2^exponent − 1. A message setup records its exponent in the same way.
- R3: A produced address equals (page frame number of page `m >> eppLog2`) shifted left by PAGE_SHIFT, plus (`m` mod entries per page) × descriptor size. Here `m` is the device pointer AND the index mask. The pointer keeps counting, so the address wraps back to page 0, slot 0 after mask + 1 steps.
- R4: A request pop when the host producer index differs from the device pointer returns the address of the pointer's slot (`reqAddrValid` for one cycle, in the cycle after the pop) and advances the pointer by one. When the two are equal, it raises `reqEmpty` for one cycle and the pointer holds.
- R5: A request flush copies the device request pointer into `reqConsIdx`. If a pop is accepted in the same cycle, the copied value already includes that pop.
- R6: A completion allocation always returns the current slot address and advances the pointer, with no check against the host. A completion flush copies the pointer into `cmpProdIdx`, and the copied value includes an allocation made in the same cycle.
- R7: A message is accepted only when (msgProdIdx − hostMsgCons) mod 2^32 is less than mask + 1. An accepted message returns its slot address and raises `msgProdIdx` by one at once. A refused message raises `msgDropped` for one cycle and changes nothing.
- R8: A message setup issued while the data rings are not set up has no effect. A message put before a successful message setup is dropped.
- R9: A data setup issued at any time returns both data pointers, `reqConsIdx` and `cmpProdIdx` to zero and loads the new exponents. The message ring state is untouched.
- R10: A request pop before any data setup reports `reqEmpty`. A completion allocation before any data setup produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Write one page frame number |
| cfgRing | input | 2 | Target ring of the write: 0 request, 1 completion, 2 message |
| cfgPage | input | PG_IDX_W | Page slot written |
| cfgPfn | input | PFN_W | Page frame number |
| setupData | input | 1 | Commit request and completion ring geometry |
| setupReqPages | input | PG_CNT_W | Request ring page count |
| setupCmpPages | input | PG_CNT_W | Completion ring page count |
| setupMsg | input | 1 | Commit message ring geometry |
| setupMsgPages | input | PG_CNT_W | Message ring page count |
| reqPop | input | 1 | Take the next request descriptor |
| reqFlush | input | 1 | Publish the request consumer index |
| hostReqProd | input | 32 | Host request producer index |
| cmpAlloc | input | 1 | Take the next completion slot |
| cmpFlush | input | 1 | Publish the completion producer index |
| msgPut | input | 1 | Take the next message slot if room |
| hostMsgCons | input | 32 | Host message consumer index |
| reqAddr | output | ADDR_W | Request descriptor address |
| reqAddrValid | output | 1 | Request address produced |
| reqEmpty | output | 1 | Request pop found nothing |
| cmpAddr | output | ADDR_W | Completion slot address |
| cmpAddrValid | output | 1 | Completion address produced |
| msgAddr | output | ADDR_W | Message slot address |
| msgAddrValid | output | 1 | Message address produced |
| msgDropped | output | 1 | Message refused |
| reqConsIdx | output | 32 | Published request consumer index |
| cmpProdIdx | output | 32 | Published completion producer index |
| msgProdIdx | output | 32 | Published message producer index |
| reqLog2 | output | 6 | Request ring length exponent |
| cmpLog2 | output | 6 | Completion ring length exponent |
| msgLog2 | output | 6 | Message ring length exponent |

## Verification
The bench builds the block with a 64-byte page, four page slots and descriptor sizes of 16, 8 and 32 bytes. That gives 4, 8 and 2 entries per page. With these sizes a full ring holds only 4 to 32 entries, so index wrap-around, page-boundary crossing and a full message ring all occur within a few dozen operations. The small pages also let each address check tell a wrong page select apart from a wrong in-page offset.

// File: rtl/ring_addr_pkg.sv
package ring_addr_pkg;

  localparam int NUM_RINGS = 3;

  typedef enum logic [1:0] {
    RING_REQ = 2'd0,
    RING_CMP = 2'd1,
    RING_MSG = 2'd2
  } ring_sel_e;

  // Strobes from control to datapath, at most one action per field per cycle.
  typedef struct packed {
    logic dataInit;
    logic msgInit;
    logic reqTake;
    logic reqMiss;
    logic reqPublish;
    logic cmpTake;
    logic cmpPublish;
    logic msgTake;
    logic msgMiss;
  } ring_strobe_t;

  // Number of significant bits in a 32-bit value.
  function automatic logic [5:0] bitWidth(input logic [31:0] v);
    logic [5:0] w;
    w = '0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) w = 6'(i + 1);
    end
    return w;
  endfunction

  function automatic logic [31:0] lenMask(input logic [5:0] w);
    return (w >= 6'd32) ? '1 : ((32'd1 << w) - 32'd1);
  endfunction

endpackage

// File: rtl/ring_page_tbl.sv
module ring_page_tbl #(
  parameter int PFN_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int MAX_PAGES  = 8,
  parameter int DESC_LOG2  = 7,
  localparam int PG_IDX_W  = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1,
  localparam int ADDR_W    = PFN_W + PAGE_SHIFT,
  localparam int EPP_LOG2  = PAGE_SHIFT - DESC_LOG2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [PG_IDX_W-1:0] wrPage,
  input  logic [PFN_W-1:0]    wrPfn,
  input  logic [31:0]         maskedIdx,
  output logic [ADDR_W-1:0]   slotAddr
);

  logic [PFN_W-1:0]    pfnQ [MAX_PAGES];
  logic [31:0]         pageIdx;
  logic [EPP_LOG2-1:0] slotIdx;
  logic [PFN_W-1:0]    pageBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < MAX_PAGES; p++) pfnQ[p] <= '0;
    end else if (wrEn && (int'(wrPage) < MAX_PAGES)) begin
      pfnQ[wrPage] <= wrPfn;
    end
  end

  // Entries per page is a power of two: divide and modulo are bit slices.
  always_comb begin
    pageIdx  = maskedIdx >> EPP_LOG2;
    slotIdx  = maskedIdx[EPP_LOG2-1:0];
    pageBase = (pageIdx < 32'(MAX_PAGES)) ? pfnQ[pageIdx[PG_IDX_W-1:0]] : '0;
    slotAddr = (ADDR_W'(pageBase) << PAGE_SHIFT) + (ADDR_W'(slotIdx) << DESC_LOG2);
  end

endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_addr_pkg::*;
(
  input  logic         setupData,
  input  logic         setupMsg,
  input  logic         reqPop,
  input  logic         reqFlush,
  input  logic         cmpAlloc,
  input  logic         cmpFlush,
  input  logic         msgPut,
  input  logic [31:0]  hostReqProd,
  input  logic [31:0]  hostMsgCons,
  input  logic         dataValid,
  input  logic         msgValid,
  input  logic [31:0]  reqPtr,
  input  logic [31:0]  msgPub,
  input  logic [31:0]  msgMask,
  output ring_strobe_t st
);

  logic        dataLive;
  logic [32:0] msgUsed;
  logic [32:0] msgCap;
  logic        msgRoom;

  always_comb begin
    dataLive = dataValid && !setupData;
    msgUsed  = {1'b0, msgPub - hostMsgCons};
    msgCap   = {1'b0, msgMask} + 33'd1;
    msgRoom  = msgUsed < msgCap;

    st            = '0;
    st.dataInit   = setupData;
    st.msgInit    = setupMsg && dataValid;
    st.reqTake    = reqPop && dataLive && (hostReqProd != reqPtr);
    st.reqMiss    = reqPop && !st.reqTake;
    st.reqPublish = reqFlush && dataLive;
    st.cmpTake    = cmpAlloc && dataLive;
    st.cmpPublish = cmpFlush && dataLive;
    st.msgTake    = msgPut && msgValid && !setupMsg && msgRoom;
    st.msgMiss    = msgPut && !st.msgTake;
  end

endmodule

// File: rtl/ring_dp.sv
module ring_dp
  import ring_addr_pkg::*;
#(
  parameter int PFN_W         = 32,
  parameter int PAGE_SHIFT    = 12,
  parameter int MAX_PAGES     = 8,
  parameter int REQ_DESC_LOG2 = 7,
  parameter int CMP_DESC_LOG2 = 5,
  parameter int MSG_DESC_LOG2 = 7,
  localparam int PG_IDX_W     = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1,
  localparam int PG_CNT_W     = $clog2(MAX_PAGES + 1),
  localparam int ADDR_W       = PFN_W + PAGE_SHIFT
) (
  input  logic                clk,
  input  logic                rstN,
  input  ring_strobe_t        st,
  input  logic                cfgWe,
  input  logic [1:0]          cfgRing,
  input  logic [PG_IDX_W-1:0] cfgPage,
  input  logic [PFN_W-1:0]    cfgPfn,
  input  logic [PG_CNT_W-1:0] setupReqPages,
  input  logic [PG_CNT_W-1:0] setupCmpPages,
  input  logic [PG_CNT_W-1:0] setupMsgPages,
  output logic                dataValid,
  output logic                msgValid,
  output logic [31:0]         reqPtr,
  output logic [31:0]         msgPub,
  output logic [31:0]         msgMask,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic                reqAddrValid,
  output logic                reqEmpty,
  output logic [ADDR_W-1:0]   cmpAddr,
  output logic                cmpAddrValid,
  output logic [ADDR_W-1:0]   msgAddr,
  output logic                msgAddrValid,
  output logic                msgDropped,
  output logic [31:0]         reqConsIdx,
  output logic [31:0]         cmpProdIdx,
  output logic [31:0]         msgProdIdx,
  output logic [5:0]          reqLog2,
  output logic [5:0]          cmpLog2,
  output logic [5:0]          msgLog2
);

  logic [31:0]       ptrQ     [NUM_RINGS];
  logic [5:0]        log2Q    [NUM_RINGS];
  logic [31:0]       maskW    [NUM_RINGS];
  logic [5:0]        initLog2 [NUM_RINGS];
  logic [PG_CNT_W-1:0] pagesW [NUM_RINGS];
  logic [ADDR_W-1:0] slotAddr [NUM_RINGS];

  logic              dataValidQ, msgValidQ;
  logic [31:0]       reqConsQ, cmpProdQ, msgProdQ;
  logic [ADDR_W-1:0] reqAddrQ, cmpAddrQ, msgAddrQ;
  logic              reqHitQ, reqEmptyQ, cmpHitQ, msgHitQ, msgDropQ;

  assign pagesW[0] = setupReqPages;
  assign pagesW[1] = setupCmpPages;
  assign pagesW[2] = setupMsgPages;

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    localparam int DL  = (r == 0) ? REQ_DESC_LOG2 : (r == 1) ? CMP_DESC_LOG2 : MSG_DESC_LOG2;
    localparam int EPL = PAGE_SHIFT - DL;

    assign maskW[r]    = lenMask(log2Q[r]);
    assign initLog2[r] = bitWidth((32'(pagesW[r]) << EPL) - 32'd1);

    ring_page_tbl #(
      .PFN_W      (PFN_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .MAX_PAGES  (MAX_PAGES),
      .DESC_LOG2  (DL)
    ) u_tbl (
      .clk       (clk),
      .rstN      (rstN),
      .wrEn      (cfgWe && (cfgRing == 2'(r))),
      .wrPage    (cfgPage),
      .wrPfn     (cfgPfn),
      .maskedIdx (ptrQ[r] & maskW[r]),
      .slotAddr  (slotAddr[r])
    );
  end

  // Pointer, geometry and published-index state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_RINGS; r++) begin
        ptrQ[r]  <= '0;
        log2Q[r] <= '0;
      end
      dataValidQ <= 1'b0;
      msgValidQ  <= 1'b0;
      reqConsQ   <= '0;
      cmpProdQ   <= '0;
      msgProdQ   <= '0;
    end else begin
      if (st.dataInit) begin
        ptrQ[0]    <= '0;
        ptrQ[1]    <= '0;
        log2Q[0]   <= initLog2[0];
        log2Q[1]   <= initLog2[1];
        reqConsQ   <= '0;
        cmpProdQ   <= '0;
        dataValidQ <= 1'b1;
      end else begin
        if (st.reqTake)    ptrQ[0]  <= ptrQ[0] + 32'd1;
        if (st.reqPublish) reqConsQ <= st.reqTake ? ptrQ[0] + 32'd1 : ptrQ[0];
        if (st.cmpTake)    ptrQ[1]  <= ptrQ[1] + 32'd1;
        if (st.cmpPublish) cmpProdQ <= st.cmpTake ? ptrQ[1] + 32'd1 : ptrQ[1];
      end
      if (st.msgInit) begin
        ptrQ[2]   <= '0;
        log2Q[2]  <= initLog2[2];
        msgProdQ  <= '0;
        msgValidQ <= 1'b1;
      end else if (st.msgTake) begin
        ptrQ[2]  <= ptrQ[2] + 32'd1;
        msgProdQ <= ptrQ[2] + 32'd1;
      end
    end
  end

  // One-cycle result strobes with held addresses.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddrQ  <= '0;
      cmpAddrQ  <= '0;
      msgAddrQ  <= '0;
      reqHitQ   <= 1'b0;
      reqEmptyQ <= 1'b0;
      cmpHitQ   <= 1'b0;
      msgHitQ   <= 1'b0;
      msgDropQ  <= 1'b0;
    end else begin
      if (st.reqTake) reqAddrQ <= slotAddr[0];
      if (st.cmpTake) cmpAddrQ <= slotAddr[1];
      if (st.msgTake) msgAddrQ <= slotAddr[2];
      reqHitQ   <= st.reqTake;
      reqEmptyQ <= st.reqMiss;
      cmpHitQ   <= st.cmpTake;
      msgHitQ   <= st.msgTake;
      msgDropQ  <= st.msgMiss;
    end
  end

  assign dataValid    = dataValidQ;
  assign msgValid     = msgValidQ;
  assign reqPtr       = ptrQ[0];
  assign msgPub       = msgProdQ;
  assign msgMask      = maskW[2];
  assign reqAddr      = reqAddrQ;
  assign reqAddrValid = reqHitQ;
  assign reqEmpty     = reqEmptyQ;
  assign cmpAddr      = cmpAddrQ;
  assign cmpAddrValid = cmpHitQ;
  assign msgAddr      = msgAddrQ;
  assign msgAddrValid = msgHitQ;
  assign msgDropped   = msgDropQ;
  assign reqConsIdx   = reqConsQ;
  assign cmpProdIdx   = cmpProdQ;
  assign msgProdIdx   = msgProdQ;
  assign reqLog2      = log2Q[0];
  assign cmpLog2      = log2Q[1];
  assign msgLog2      = log2Q[2];

  // R4: the request pointer only steps by one or restarts at zero.
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (ptrQ[0] != $past(ptrQ[0])) |-> ((ptrQ[0] == $past(ptrQ[0]) + 32'd1) || (ptrQ[0] == '0)));

  // R4: a pop yields either an address or empty, never both.
  a_r4_hit_or_empty: assert property (@(posedge clk) disable iff (!rstN)
    !(reqHitQ && reqEmptyQ));

  // R5: the published consumer index moves only on a flush or setup.
  a_r5_cons_publish: assert property (@(posedge clk) disable iff (!rstN)
    (reqConsQ != $past(reqConsQ)) |-> ($past(st.reqPublish) || $past(st.dataInit)));

  // R6: the published completion index moves only on a flush or setup.
  a_r6_prod_publish: assert property (@(posedge clk) disable iff (!rstN)
    (cmpProdQ != $past(cmpProdQ)) |-> ($past(st.cmpPublish) || $past(st.dataInit)));

  // R7: the message producer index advances one message at a time.
  a_r7_msg_step: assert property (@(posedge clk) disable iff (!rstN)
    (msgProdQ != $past(msgProdQ)) |-> ((msgProdQ == $past(msgProdQ) + 32'd1) || $past(st.msgInit)));

  // R8: no message address without a set-up message ring.
  a_r8_msg_needs_setup: assert property (@(posedge clk) disable iff (!rstN)
    msgHitQ |-> msgValidQ);

endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
  import ring_addr_pkg::*;
#(
  parameter int PFN_W         = 32,
  parameter int PAGE_SHIFT    = 12,
  parameter int MAX_PAGES     = 8,
  parameter int REQ_DESC_LOG2 = 7,
  parameter int CMP_DESC_LOG2 = 5,
  parameter int MSG_DESC_LOG2 = 7,
  localparam int PG_IDX_W     = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1,
  localparam int PG_CNT_W     = $clog2(MAX_PAGES + 1),
  localparam int ADDR_W       = PFN_W + PAGE_SHIFT
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [1:0]          cfgRing,
  input  logic [PG_IDX_W-1:0] cfgPage,
  input  logic [PFN_W-1:0]    cfgPfn,
  input  logic                setupData,
  input  logic [PG_CNT_W-1:0] setupReqPages,
  input  logic [PG_CNT_W-1:0] setupCmpPages,
  input  logic                setupMsg,
  input  logic [PG_CNT_W-1:0] setupMsgPages,
  input  logic                reqPop,
  input  logic                reqFlush,
  input  logic [31:0]         hostReqProd,
  input  logic                cmpAlloc,
  input  logic                cmpFlush,
  input  logic                msgPut,
  input  logic [31:0]         hostMsgCons,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic                reqAddrValid,
  output logic                reqEmpty,
  output logic [ADDR_W-1:0]   cmpAddr,
  output logic                cmpAddrValid,
  output logic [ADDR_W-1:0]   msgAddr,
  output logic                msgAddrValid,
  output logic                msgDropped,
  output logic [31:0]         reqConsIdx,
  output logic [31:0]         cmpProdIdx,
  output logic [31:0]         msgProdIdx,
  output logic [5:0]          reqLog2,
  output logic [5:0]          cmpLog2,
  output logic [5:0]          msgLog2
);

  ring_strobe_t st;
  logic         dataValid, msgValid;
  logic [31:0]  reqPtr, msgPub, msgMask;

  ring_ctrl u_ctrl (
    .setupData   (setupData),
    .setupMsg    (setupMsg),
    .reqPop      (reqPop),
    .reqFlush    (reqFlush),
    .cmpAlloc    (cmpAlloc),
    .cmpFlush    (cmpFlush),
    .msgPut      (msgPut),
    .hostReqProd (hostReqProd),
    .hostMsgCons (hostMsgCons),
    .dataValid   (dataValid),
    .msgValid    (msgValid),
    .reqPtr      (reqPtr),
    .msgPub      (msgPub),
    .msgMask     (msgMask),
    .st          (st)
  );

  ring_dp #(
    .PFN_W         (PFN_W),
    .PAGE_SHIFT    (PAGE_SHIFT),
    .MAX_PAGES     (MAX_PAGES),
    .REQ_DESC_LOG2 (REQ_DESC_LOG2),
    .CMP_DESC_LOG2 (CMP_DESC_LOG2),
    .MSG_DESC_LOG2 (MSG_DESC_LOG2)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .st            (st),
    .cfgWe         (cfgWe),
    .cfgRing       (cfgRing),
    .cfgPage       (cfgPage),
    .cfgPfn        (cfgPfn),
    .setupReqPages (setupReqPages),
    .setupCmpPages (setupCmpPages),
    .setupMsgPages (setupMsgPages),
    .dataValid     (dataValid),
    .msgValid      (msgValid),
    .reqPtr        (reqPtr),
    .msgPub        (msgPub),
    .msgMask       (msgMask),
    .reqAddr       (reqAddr),
    .reqAddrValid  (reqAddrValid),
    .reqEmpty      (reqEmpty),
    .cmpAddr       (cmpAddr),
    .cmpAddrValid  (cmpAddrValid),
    .msgAddr       (msgAddr),
    .msgAddrValid  (msgAddrValid),
    .msgDropped    (msgDropped),
    .reqConsIdx    (reqConsIdx),
    .cmpProdIdx    (cmpProdIdx),
    .msgProdIdx    (msgProdIdx),
    .reqLog2       (reqLog2),
    .cmpLog2       (cmpLog2),
    .msgLog2       (msgLog2)
  );

endmodule

// File: tb/ring_addr_gen_tb.sv
module ring_addr_gen_tb;

  localparam int PFN_W = 20;
  localparam int PSH   = 6;
  localparam int MAXP  = 4;
  localparam int AW    = PFN_W + PSH;
  localparam int DESCL [3] = '{4, 3, 5};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          cfgWe = 0;
  logic [1:0]    cfgRing = 0;
  logic [1:0]    cfgPage = 0;
  logic [PFN_W-1:0] cfgPfn = 0;
  logic          setupData = 0, setupMsg = 0;
  logic [2:0]    setupReqPages = 0, setupCmpPages = 0, setupMsgPages = 0;
  logic          reqPop = 0, reqFlush = 0, cmpAlloc = 0, cmpFlush = 0, msgPut = 0;
  logic [31:0]   hostReqProd = 0, hostMsgCons = 0;
  logic [AW-1:0] reqAddr, cmpAddr, msgAddr;
  logic          reqAddrValid, reqEmpty, cmpAddrValid, msgAddrValid, msgDropped;
  logic [31:0]   reqConsIdx, cmpProdIdx, msgProdIdx;
  logic [5:0]    reqLog2, cmpLog2, msgLog2;

  ring_addr_gen #(
    .PFN_W(PFN_W), .PAGE_SHIFT(PSH), .MAX_PAGES(MAXP),
    .REQ_DESC_LOG2(4), .CMP_DESC_LOG2(3), .MSG_DESC_LOG2(5)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRing(cfgRing), .cfgPage(cfgPage),
    .cfgPfn(cfgPfn), .setupData(setupData), .setupReqPages(setupReqPages),
    .setupCmpPages(setupCmpPages), .setupMsg(setupMsg), .setupMsgPages(setupMsgPages),
    .reqPop(reqPop), .reqFlush(reqFlush), .hostReqProd(hostReqProd),
    .cmpAlloc(cmpAlloc), .cmpFlush(cmpFlush), .msgPut(msgPut), .hostMsgCons(hostMsgCons),
    .reqAddr(reqAddr), .reqAddrValid(reqAddrValid), .reqEmpty(reqEmpty),
    .cmpAddr(cmpAddr), .cmpAddrValid(cmpAddrValid), .msgAddr(msgAddr),
    .msgAddrValid(msgAddrValid), .msgDropped(msgDropped), .reqConsIdx(reqConsIdx),
    .cmpProdIdx(cmpProdIdx), .msgProdIdx(msgProdIdx), .reqLog2(reqLog2),
    .cmpLog2(cmpLog2), .msgLog2(msgLog2)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          ring;
    bit          hit;
    logic [AW-1:0] addr;
    string       tag;
  } exp_t;
  exp_t sbq [$];

  // Reference model state
  logic [PFN_W-1:0] pfnT [3][MAXP];
  int          bLog2 [3] = '{0, 0, 0};
  logic [31:0] bPtr  [3] = '{0, 0, 0};
  bit          dataOk = 0, msgOk = 0;

  function automatic int widthOf(logic [31:0] v);
    int n = 0;
    while (v != 0) begin n++; v = v >> 1; end
    return n;
  endfunction

  function automatic logic [AW-1:0] expAddr(int ring, logic [31:0] ptr);
    logic [31:0] m = ptr & ((32'd1 << bLog2[ring]) - 32'd1);
    int epl = PSH - DESCL[ring];
    int pg  = int'(m >> epl);
    logic [31:0] off = m & ((32'd1 << epl) - 32'd1);
    return (AW'(pfnT[ring][pg]) << PSH) + AW'(off << DESCL[ring]);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk);
    cfgWe = 0; setupData = 0; setupMsg = 0; reqPop = 0; reqFlush = 0;
    cmpAlloc = 0; cmpFlush = 0; msgPut = 0;
  endtask

  // Scoreboard monitor
  task automatic consume(int ring, bit hit, logic [AW-1:0] addr);
    exp_t e;
    checks++;
    if (sbq.size() == 0) begin
      errors++;
      $display("FAIL unexpected result ring %0d: actual hit=%0d addr=%0h expected none", ring, hit, addr);
      return;
    end
    e = sbq.pop_front();
    if (e.ring != ring || e.hit != hit || (hit && e.addr !== addr)) begin
      errors++;
      $display("FAIL %s: actual ring=%0d hit=%0d addr=%0h expected ring=%0d hit=%0d addr=%0h",
               e.tag, ring, hit, addr, e.ring, e.hit, e.addr);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (reqAddrValid || reqEmpty) consume(0, reqAddrValid, reqAddr);
      if (cmpAddrValid)             consume(1, 1'b1, cmpAddr);
      if (msgAddrValid || msgDropped) consume(2, msgAddrValid, msgAddr);
    end
  end

  // Driver tasks
  task automatic writePfn(int ring, int page, logic [PFN_W-1:0] pfn);
    cfgWe = 1; cfgRing = 2'(ring); cfgPage = 2'(page); cfgPfn = pfn;
    pfnT[ring][page] = pfn;
    pulse();
  endtask

  task automatic doSetupData(int rp, int cp);
    setupData = 1; setupReqPages = 3'(rp); setupCmpPages = 3'(cp);
    bLog2[0] = widthOf(32'(rp * 4) - 1);
    bLog2[1] = widthOf(32'(cp * 8) - 1);
    bPtr[0] = 0; bPtr[1] = 0; dataOk = 1;
    pulse();
  endtask

  task automatic doSetupMsg(int mp);
    setupMsg = 1; setupMsgPages = 3'(mp);
    if (dataOk) begin
      bLog2[2] = widthOf(32'(mp * 2) - 1);
      bPtr[2] = 0; msgOk = 1;
    end
    pulse();
  endtask

  task automatic popReq(string tag, bit withFlush);
    reqPop = 1; reqFlush = withFlush;
    if (dataOk && hostReqProd != bPtr[0]) begin
      sbq.push_back('{0, 1'b1, expAddr(0, bPtr[0]), tag});
      bPtr[0]++;
    end else begin
      sbq.push_back('{0, 1'b0, '0, tag});
    end
    pulse();
  endtask

  task automatic allocCmp(string tag, bit withFlush);
    cmpAlloc = 1; cmpFlush = withFlush;
    if (dataOk) begin
      sbq.push_back('{1, 1'b1, expAddr(1, bPtr[1]), tag});
      bPtr[1]++;
    end
    pulse();
  endtask

  task automatic putMsg(string tag);
    logic [32:0] used = {1'b0, bPtr[2] - hostMsgCons};
    logic [32:0] cap  = 33'd1 << bLog2[2];
    msgPut = 1;
    if (msgOk && used < cap) begin
      sbq.push_back('{2, 1'b1, expAddr(2, bPtr[2]), tag});
      bPtr[2]++;
    end else begin
      sbq.push_back('{2, 1'b0, '0, tag});
    end
    pulse();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reqConsIdx", reqConsIdx, 0);
    check("R1 cmpProdIdx", cmpProdIdx, 0);
    check("R1 msgProdIdx", msgProdIdx, 0);
    check("R1 log2s", {reqLog2, cmpLog2, msgLog2}, 0);
    check("R1 strobes", {reqAddrValid, reqEmpty, cmpAddrValid, msgAddrValid, msgDropped}, 0);
    rstN = 1;
    @(negedge clk);

    // R10: activity before data setup
    hostReqProd = 3;
    popReq("R10 pop before setup", 0);
    allocCmp("R10 alloc before setup", 0);
    // R8: message setup before data setup is ignored, put is dropped
    doSetupMsg(2);
    check("R8 msgLog2 unchanged", msgLog2, 0);
    putMsg("R8 put before msg setup");

    for (int r = 0; r < 3; r++)
      for (int p = 0; p < MAXP; p++)
        writePfn(r, p, PFN_W'(20'h01000 * (r + 1) + p * 7 + 3));

    // R2: geometry
    doSetupData(4, 2);
    check("R2 reqLog2", reqLog2, 6'(bLog2[0]));
    check("R2 cmpLog2", cmpLog2, 6'(bLog2[1]));
    check("R2 reqLog2 value", reqLog2, 4);

    // R3 R4: pops across a page boundary then empty
    hostReqProd = 5;
    for (int i = 0; i < 6; i++) popReq("R4 pop to empty", 0);
    reqFlush = 1; pulse();
    check("R5 reqConsIdx", reqConsIdx, 5);

    // R3: pointer wraps past the mask
    hostReqProd = 20;
    for (int i = 0; i < 14; i++) popReq("R3 wrap pop", 0);
    popReq("R5 pop with flush", 1);
    check("R5 reqConsIdx same-cycle pop", reqConsIdx, 20);
    popReq("R4 empty after wrap", 0);

    // R6: completion slots without overflow check
    for (int i = 0; i < 19; i++) allocCmp("R6 alloc", 0);
    allocCmp("R6 alloc with flush", 1);
    check("R6 cmpProdIdx", cmpProdIdx, 20);

    // R7: message room
    doSetupMsg(2);
    check("R2 msgLog2", msgLog2, 6'(bLog2[2]));
    hostMsgCons = 0;
    for (int i = 0; i < 5; i++) putMsg("R7 fill ring");
    check("R7 msgProdIdx full", msgProdIdx, 4);
    hostMsgCons = 2;
    for (int i = 0; i < 3; i++) putMsg("R7 after consume");
    check("R7 msgProdIdx", msgProdIdx, 6);
    hostMsgCons = 7;
    putMsg("R7 modulo difference drop");
    check("R7 msgProdIdx held", msgProdIdx, 6);

    // R9: re-setup of data rings mid-run
    doSetupData(1, 4);
    check("R9 reqConsIdx", reqConsIdx, 0);
    check("R9 cmpProdIdx", cmpProdIdx, 0);
    check("R9 reqLog2", reqLog2, 2);
    check("R9 cmpLog2", cmpLog2, 5);
    check("R9 msgProdIdx untouched", msgProdIdx, 6);
    hostReqProd = 1;
    popReq("R9 pop after re-setup", 0);
    allocCmp("R9 alloc after re-setup", 0);
    hostMsgCons = 6;
    putMsg("R9 msg ring still live");

    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", 64'(sbq.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule